// File: doc/BRIEF.md
# Byte-Wide Serial Port Register Model

This block presents the eight-register, byte-wide programming interface of a classic 16550-style serial port. It has no serial line behind it. A host bus reads and writes registers through a 3-bit offset and separate read and write strobes. Bytes written to the data register land in a transmit ring that other logic drains. Received bytes enter a receive ring through a push port, and the host reads them back from the data register.

Both rings are overwrite rings. When a ring is full, a new byte replaces the oldest one. In the receive ring this also raises an overrun flag. Several reads have side effects: the overrun flag clears when the host reads the data or the line status register, and a pending transmit-empty event clears when the host reads the identification register. The block ranks its interrupt causes in a fixed order and drives a level interrupt whose active polarity is a configuration input.

For a linked pair, a peer enable diverts data-register writes to a registered push output. That output is wired to the other instance's receive push port. A mark input on the receive side makes the incoming byte also raise the receiver's transmit-empty pending flag.

Top module: `uart_reg_block`

## Requirements
- R1: After reset the divisor bytes hold (CLK_HZ/115200)>>4, low byte and high byte. IER, LCR, FCR and the scratch register read 0, and the identification register (offset 2) reads 0x01.
- R2: While LCR (offset 3) bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. A write there does not touch the transmit ring or IER.
- R3: An IER write (offset 1) keeps bits 3:0. Bits 7:4 always read 0. IER bit 0 enables the receive cause, bit 1 the transmit-empty cause, and bit 2 the line-status cause.
- R4: An FCR write (offset 2) with bit 0 clear stores zero. With bit 0 set, it stores only bits 0, 3, 7 and 6, and it empties the receive ring when bit 1 is also set.
- R5: Writes to offsets 4, 5 and 6 change nothing. Offsets 4 and 6 read 0. The scratch register at offset 7 reads back what was written.
- R6: With the peer link off, a data write (offset 0, LCR bit 7 clear) appends the byte to the transmit ring and sets the transmit-empty pending flag. `tx_dout` shows the oldest byte, `tx_level` shows the count, and `tx_pop` removes the oldest byte.
- R7: With `peer_en` high, a data write leaves the transmit ring and the local pending flag alone. In the next cycle it pulses `peer_push` for one cycle with the byte on `peer_byte`. A receive push with `rx_mark` high sets the local pending flag.
- R8: A push into a full ring discards the oldest byte. A receive push that finds the ring full, with no pop in the same cycle, sets the overrun flag.
- R9: The identification low nibble is ranked as follows: 0x6 for overrun with IER bit 2; 0xC for receive data present with IER bit 0; 0x2 for transmit-empty pending with IER bit 1; otherwise 0x1.
- R10: An identification read returns 0xC0 OR the code when FCR bit 0 is stored set. A read that returns code 0x2 clears the pending flag.
- R11: LSR (offset 5) reads with bits 6 and 5 set, bit 1 as overrun and bit 0 as receive data present. A status read or a data read clears the overrun flag. A data read pops the receive ring, and returns 0xFF when the ring is empty.
- R12: `irq` equals "code is not 0x1" when `irq_active_low` is 0, and its inverse when `irq_active_low` is 1.
- R13: `rdata` updates in the cycle after a read strobe and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| irq_active_low | input | 1 | Interrupt polarity select |
| irq | output | 1 | Interrupt line |
| rx_push | input | 1 | Push a byte into the receive ring |
| rx_byte | input | 8 | Byte to push |
| rx_mark | input | 1 | Push also sets the transmit-empty pending flag |
| tx_pop | input | 1 | Remove oldest transmit byte |
| tx_dout | output | 8 | Oldest transmit byte |
| tx_level | output | TX_AW+1 | Transmit ring count |
| peer_en | input | 1 | Divert data writes to the peer port |
| peer_push | output | 1 | Registered push toward the peer |
| peer_byte | output | 8 | Byte toward the peer |

## Verification
The bench sets CLK_HZ to 552960000, which gives a reset divisor of 300. Both divisor bytes are then non-trivial (0x2C and 0x01), so a swapped or truncated byte shows up. Both rings are built four deep (TX_AW = RX_AW = 2). That puts the full-ring overwrite, overrun ranking above receive data, and overrun clearing within a handful of pushes, and the transmit-ring wrap within a handful of writes.

// File: rtl/uart_reg_block.sv
module uart_reg_block #(
  parameter int CLK_HZ = 1843200,
  parameter int TX_AW  = 4,
  parameter int RX_AW  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       addr,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  input  logic             rd_en,
  output logic [7:0]       rdata,
  input  logic             irq_active_low,
  output logic             irq,
  input  logic             rx_push,
  input  logic [7:0]       rx_byte,
  input  logic             rx_mark,
  input  logic             tx_pop,
  output logic [7:0]       tx_dout,
  output logic [TX_AW:0]   tx_level,
  input  logic             peer_en,
  output logic             peer_push,
  output logic [7:0]       peer_byte
);
  localparam int TX_D = 1 << TX_AW;
  localparam int RX_D = 1 << RX_AW;
  localparam logic [TX_AW:0] TX_FULL = (TX_AW+1)'(TX_D);
  localparam logic [RX_AW:0] RX_FULL = (RX_AW+1)'(RX_D);
  localparam logic [15:0] DIV_RST = 16'((CLK_HZ / 115200) >> 4);
  localparam logic [3:0] C_LS = 4'h6, C_RX = 4'hC, C_TX = 4'h2, C_NONE = 4'h1;
  localparam logic [7:0] FCR_KEEP = 8'hC9;

  logic [7:0] lcr, fcr, scr, dll, dlh;
  logic [3:0] ier;
  logic       ovr, thre_pend;
  logic [3:0] code;

  logic [7:0]       tx_mem [TX_D];
  logic [TX_AW-1:0] tx_wp, tx_rp;
  logic [TX_AW:0]   tx_cnt;
  logic [7:0]       rx_mem [RX_D];
  logic [RX_AW-1:0] rx_wp, rx_rp;
  logic [RX_AW:0]   rx_cnt;

  wire dlab    = lcr[7];
  wire wr_thr  = wr_en && addr == 3'd0 && !dlab;
  wire rd_rbr  = rd_en && addr == 3'd0 && !dlab;
  wire rd_iir  = rd_en && addr == 3'd2;
  wire rd_lsr  = rd_en && addr == 3'd5;
  wire tx_in   = wr_thr && !peer_en;
  wire tx_out  = tx_pop && tx_cnt != '0;
  wire tx_full = tx_cnt == TX_FULL;
  wire rx_out  = rd_rbr && rx_cnt != '0;
  wire rx_full = rx_cnt == RX_FULL;
  wire rx_flush = wr_en && addr == 3'd2 && wdata[0] && wdata[1];
  wire rx_has  = rx_cnt != '0;

  always_comb begin
    if (ovr && ier[2])                code = C_LS;
    else if (rx_has && ier[0])        code = C_RX;
    else if (thre_pend && ier[1])     code = C_TX;
    else                              code = C_NONE;
  end

  assign irq      = (code != C_NONE) ^ irq_active_low;
  assign tx_dout  = tx_mem[tx_rp];
  assign tx_level = tx_cnt;

  always_ff @(posedge clk) begin
    if (tx_in) tx_mem[tx_wp] <= wdata;
    if (rx_push && !rx_flush) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in) tx_wp <= tx_wp + 1'b1;
      if (tx_out || (tx_in && tx_full)) tx_rp <= tx_rp + 1'b1;
      if (tx_in && (!tx_full || tx_out) && !tx_out) tx_cnt <= tx_cnt + 1'b1;
      else if (tx_out && !tx_in) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_out || (rx_push && rx_full)) rx_rp <= rx_rp + 1'b1;
      if (rx_push && !rx_full && !rx_out) rx_cnt <= rx_cnt + 1'b1;
      else if (rx_out && !rx_push) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcr <= '0; fcr <= '0; scr <= '0; ier <= '0;
      dll <= DIV_RST[7:0]; dlh <= DIV_RST[15:8];
      peer_push <= 1'b0; peer_byte <= '0;
    end else begin
      peer_push <= wr_thr && peer_en;
      if (wr_thr && peer_en) peer_byte <= wdata;
      if (wr_en) begin
        case (addr)
          3'd0: if (dlab) dll <= wdata;
          3'd1: if (dlab) dlh <= wdata; else ier <= wdata[3:0];
          3'd2: fcr <= wdata[0] ? (wdata & FCR_KEEP) : 8'h00;
          3'd3: lcr <= wdata;
          3'd7: scr <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr <= 1'b0;
      thre_pend <= 1'b0;
    end else begin
      if (rx_push && !rx_flush && rx_full && !rx_out) ovr <= 1'b1;
      else if (rd_rbr || rd_lsr) ovr <= 1'b0;
      if (tx_in || (rx_push && rx_mark)) thre_pend <= 1'b1;
      else if (rd_iir && code == C_TX) thre_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      case (addr)
        3'd0: rdata <= dlab ? dll : (rx_has ? rx_mem[rx_rp] : 8'hFF);
        3'd1: rdata <= dlab ? dlh : {4'h0, ier};
        3'd2: rdata <= {fcr[0] ? 2'b11 : 2'b00, 2'b00, code};
        3'd3: rdata <= lcr;
        3'd5: rdata <= {1'b0, 1'b1, 1'b1, 3'b000, ovr, rx_has};
        3'd7: rdata <= scr;
        default: rdata <= 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/uart_reg_block_chk.sv
module uart_reg_block_chk #(
  parameter int TX_AW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     addr,
  input logic           wr_en,
  input logic [7:0]     wdata,
  input logic           rd_en,
  input logic [7:0]     rdata,
  input logic           rx_push,
  input logic           tx_pop,
  input logic [TX_AW:0] tx_level,
  input logic           peer_en,
  input logic           peer_push,
  input logic [7:0]     peer_byte,
  input logic [7:0]     lcr,
  input logic [7:0]     fcr,
  input logic           ovr
);
  p_ier_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == 3'd1 && !lcr[7]) |-> rdata[7:4] == 4'h0);

  p_fcr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && addr == 3'd2 && !wdata[0]) |-> fcr == 8'h00);

  p_peer_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && !lcr[7] && peer_en && !tx_pop)
      |=> peer_push && peer_byte == $past(wdata) && $stable(tx_level));

  p_lsr_tx_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == 3'd5) |-> rdata[6:5] == 2'b11);

  p_ovr_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && (addr == 3'd5 || (addr == 3'd0 && !lcr[7])) && !rx_push) |-> !ovr);

  p_iir_prefix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && addr == 3'd2 && fcr[0]) |-> rdata[7:6] == 2'b11);

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind uart_reg_block uart_reg_block_chk #(.TX_AW(TX_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .rx_push(rx_push), .tx_pop(tx_pop),
  .tx_level(tx_level), .peer_en(peer_en), .peer_push(peer_push),
  .peer_byte(peer_byte), .lcr(lcr), .fcr(fcr), .ovr(ovr)
);

// File: tb/test_uart_reg_block.sv
module test_uart_reg_block;
  localparam int AW = 2;
  logic clk = 0, rst_n = 0;
  logic [2:0] addr = '0;
  logic wr_en = 0, rd_en = 0, irq_active_low = 0;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic rx_push = 0, rx_mark = 0, tx_pop = 0, peer_en = 0;
  logic [7:0] rdata, tx_dout, peer_byte;
  logic [AW:0] tx_level;
  logic irq, peer_push;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  uart_reg_block #(.CLK_HZ(552960000), .TX_AW(AW), .RX_AW(AW)) i_uart_reg_block (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .irq_active_low(irq_active_low), .irq(irq),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_mark(rx_mark), .tx_pop(tx_pop),
    .tx_dout(tx_dout), .tx_level(tx_level), .peer_en(peer_en),
    .peer_push(peer_push), .peer_byte(peer_byte));

  always @(posedge clk) begin
    if (rst_n && rd_en) begin
      #2;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R13 unexpected read result act=%02h exp=none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          bad++;
          $display("FAIL %s act=%02h exp=%02h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic rxp(input logic [7:0] d, input logic m);
    @(negedge clk); rx_byte = d; rx_mark = m; rx_push = 1;
    @(negedge clk); rx_push = 0; rx_mark = 0;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h", t, act, e);
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(3, 8'h00, "R1 lcr reset");
    rd(2, 8'h01, "R1 iir reset");
    rd(1, 8'h00, "R1 ier reset");
    rd(7, 8'h00, "R1 scr reset");
    chk({7'b0, irq}, 8'h00, "R12 irq idle high-active");
    // R2 divisor latch
    wr(3, 8'h80);
    rd(0, 8'h2C, "R1 R2 divisor low");
    rd(1, 8'h01, "R1 R2 divisor high");
    wr(0, 8'h55); wr(1, 8'h77);
    rd(0, 8'h55, "R2 dll write");
    rd(1, 8'h77, "R2 dlh write");
    chk(8'(tx_level), 8'h00, "R2 no tx push under dlab");
    wr(3, 8'h03);
    rd(3, 8'h03, "R2 lcr");
    rd(1, 8'h00, "R2 ier untouched");
    // R3
    wr(1, 8'hFF);
    rd(1, 8'h0F, "R3 ier mask");
    rd(2, 8'h01, "R9 nothing pending");
    // R5
    wr(7, 8'hA5); rd(7, 8'hA5, "R5 scratch");
    wr(4, 8'hFF); wr(5, 8'h00); wr(6, 8'hFF);
    rd(4, 8'h00, "R5 mcr reads 0");
    rd(6, 8'h00, "R5 msr reads 0");
    rd(5, 8'h60, "R5 R11 lsr idle");
    // R4 / R10
    wr(2, 8'hFF); rd(2, 8'hC1, "R4 R10 fifo on prefix");
    wr(2, 8'h0E); rd(2, 8'h01, "R4 fcr cleared");
    wr(1, 8'h00);
    rxp(8'h10, 0); rxp(8'h20, 0); rxp(8'h30, 0);
    rd(5, 8'h61, "R11 data ready");
    wr(2, 8'h03);
    rd(5, 8'h60, "R4 rx flush");
    // R6 local THR
    wr(0, 8'h11); wr(0, 8'h22);
    chk(8'(tx_level), 8'h02, "R6 tx level");
    chk(tx_dout, 8'h11, "R6 tx head");
    @(negedge clk); tx_pop = 1; @(negedge clk); tx_pop = 0;
    chk(tx_dout, 8'h22, "R6 tx pop head");
    chk(8'(tx_level), 8'h01, "R6 tx pop level");
    rd(2, 8'hC1, "R9 pending masked");
    wr(1, 8'h02);
    chk({7'b0, irq}, 8'h01, "R12 irq asserted high");
    rd(2, 8'hC2, "R9 R10 thre code");
    rd(2, 8'hC1, "R10 pending cleared");
    chk({7'b0, irq}, 8'h00, "R12 irq released");
    irq_active_low = 1;
    @(negedge clk);
    chk({7'b0, irq}, 8'h01, "R12 low-active idle");
    wr(0, 8'h33);
    chk({7'b0, irq}, 8'h00, "R12 low-active asserted");
    rd(2, 8'hC2, "R10 thre again");
    irq_active_low = 0;
    // R8 tx overwrite
    wr(0, 8'h44); wr(0, 8'h55); wr(0, 8'h66);
    chk(8'(tx_level), 8'h04, "R8 tx level full");
    chk(tx_dout, 8'h33, "R8 tx oldest dropped");
    // R8 / R9 / R11 rx path
    wr(1, 8'h07);
    rxp(8'hA1, 0);
    rd(2, 8'hCC, "R9 rx over thre");
    rxp(8'hA2, 0); rxp(8'hA3, 0); rxp(8'hA4, 0); rxp(8'hA5, 0);
    rd(2, 8'hC6, "R8 R9 overrun top");
    rd(5, 8'h63, "R11 lsr overrun");
    rd(5, 8'h61, "R11 overrun cleared by lsr");
    rd(2, 8'hCC, "R9 rx after overrun");
    rd(0, 8'hA2, "R8 rx oldest dropped");
    rd(0, 8'hA3, "R11 rx pop");
    rd(0, 8'hA4, "R11 rx pop");
    rd(0, 8'hA5, "R11 rx pop");
    rd(0, 8'hFF, "R11 empty read");
    rd(5, 8'h60, "R11 lsr empty");
    rd(2, 8'hC2, "R9 thre after rx drained");
    rd(2, 8'hC1, "R10 cleared");
    rxp(8'hB1, 0); rxp(8'hB2, 0); rxp(8'hB3, 0); rxp(8'hB4, 0); rxp(8'hB5, 0);
    rd(0, 8'hB2, "R11 data read with overrun");
    rd(5, 8'h61, "R11 overrun cleared by data read");
    rd(0, 8'hB3, "R11 drain"); rd(0, 8'hB4, "R11 drain"); rd(0, 8'hB5, "R11 drain");
    // R7 mark and peer
    wr(1, 8'h02);
    rxp(8'h77, 1);
    rd(2, 8'hC2, "R7 mark sets pending");
    rd(0, 8'h77, "R7 marked byte");
    peer_en = 1;
    wr(0, 8'h9A);
    chk({7'b0, peer_push}, 8'h01, "R7 peer push");
    chk(peer_byte, 8'h9A, "R7 peer byte");
    chk(8'(tx_level), 8'h04, "R7 tx untouched");
    @(negedge clk);
    chk({7'b0, peer_push}, 8'h00, "R7 peer pulse one cycle");
    rd(2, 8'hC1, "R7 no local pending");
    peer_en = 0;
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R13 missing reads act=%0d exp=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule